// File: doc/BRIEF.md
# Framed Stream Receive Buffer

This block sits behind a framed link receiver whose user port offers valid, data, byte-enable and end-of-frame marks but no way to pause the sender. It takes every beat the link presents, writes it into an internal beat store and replays whole frames on an AXI4-Stream master port, where the downstream consumer may stall at will. Incoming words use ascending bit numbering, with bit 0 as the most significant bit. The block turns them into the usual descending form.

For each frame that fits, the block works out its length in bytes: eight bytes for every non-final beat, plus the number of set byte-enable bits on the final beat. It reports this length with a single-cycle strobe. A frame that would not fit in the free space is discarded in full, because the write pointer winds back to where the frame began. A drop strobe marks the discard. Beats are released downstream only once their whole frame is stored, so a discarded frame never shows up in part.

Top module: `frame_rx_buffer`

## Requirements
- R1: Every beat with `rx_valid` high is taken in that cycle. Each frame that fits in the free space is delivered on the output exactly once, in arrival order, with no beat lost or repeated.
- R2: Bit order: output data bit `63-j` of a beat equals input bit `rx_data[j]` of the matching received beat, where `rx_data` is numbered [0:63] with index 0 the most significant bit.
- R3: Output keep is 8'hFF on every non-final beat, whatever `rx_keep` held on that beat. On the final beat, output keep bit `7-i` equals `rx_keep[i]`.
- R4: `m_tlast` is high on exactly the output beat that matches the received beat with `rx_last` high.
- R5: No beat of a frame is offered on the output before that frame's last beat has been taken. With an empty buffer, `m_tvalid` stays low through the whole frame and the cycle after its last beat, and rises in the cycle after that.
- R6: The cycle after a kept frame's last beat is taken, `len_valid` pulses high for one cycle. At the same time `len_bytes` = 8 × (beats − 1) + (number of ones in the final `rx_keep`).
- R7: If a beat of a frame finds the buffer full (DEPTH stored beats), the whole frame is discarded and none of its beats appear on the output. `drop_pulse` goes high for one cycle in the cycle after that frame's last beat, and `len_valid` does not pulse for it. Frames before and after it are unaffected.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` hold their values into the next cycle.
- R9: While `rst` is high and in the first cycle after it, `m_tvalid`, `len_valid` and `drop_pulse` are low and the buffer is empty.
- R10: A frame of exactly DEPTH (64) beats arriving at an empty buffer is kept, even when the output is stalled throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Link beat present; cannot be stalled |
| rx_data | input | 64 | Link beat data, numbered [0:63], bit 0 most significant |
| rx_keep | input | 8 | Byte enables, numbered [0:7]; meaningful only with rx_last |
| rx_last | input | 1 | Final beat of a frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tdata | output | 64 | Output beat data, [63:0] |
| m_tkeep | output | 8 | Output byte enables, [7:0] |
| m_tlast | output | 1 | Output final beat of a frame |
| len_valid | output | 1 | One-cycle strobe: a frame was kept |
| len_bytes | output | 16 | Byte length of that kept frame |
| drop_pulse | output | 1 | One-cycle strobe: a frame was discarded |

## Verification
The assertions assume that the link keeps to frame boundaries: every frame ends with a beat that has `rx_last` high, and a final `rx_keep` has at least one bit set. With that assumption, a reported length is never zero and never more than the buffer can hold. The stimulus builds every frame from a count of one to eight contiguous leading keep bits on the final beat, and fills non-final keep with random values, which the block must ignore. Overflows are forced while the consumer is held stalled, and the occupancy at each step is known, so the bench decides beforehand which frames are kept and which are dropped.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int unsigned BYTE_BITS = 8;

  function automatic int unsigned count_ones(input logic [255:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 256; i++) n += {31'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/frb_order.sv
module frb_order #(
  parameter int DATA_W = 64,
  localparam int KEEP_W = DATA_W / 8
) (
  input  logic [0:DATA_W-1] asc_data,
  input  logic [0:KEEP_W-1] asc_keep,
  output logic [DATA_W-1:0] desc_data,
  output logic [KEEP_W-1:0] desc_keep
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    assign desc_data[DATA_W-1-j] = asc_data[j];
  end
  for (genvar i = 0; i < KEEP_W; i++) begin : g_byte
    assign desc_keep[KEEP_W-1-i] = asc_keep[i];
  end
endmodule

// File: rtl/frb_ram.sv
module frb_ram #(
  parameter int WIDTH = 73,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/frb_writer.sv
module frb_writer
  import frb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 16,
  localparam int KEEP_W = DATA_W / 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int BSH    = $clog2(KEEP_W),
  localparam int WORD_W = DATA_W + KEEP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [KEEP_W-1:0] beat_keep,
  input  logic [PW-1:0]     rd_ptr,
  output logic [PW-1:0]     commit_ptr,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              len_valid,
  output logic [LEN_W-1:0]  len_bytes,
  output logic              drop_pulse
);
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    occupancy;
  logic             full;
  logic             discarding;
  logic             reject;
  logic [LEN_W-1:0] beat_cnt;
  logic [LEN_W-1:0] tail_bytes;

  always_comb begin
    occupancy  = wr_ptr - rd_ptr;
    full       = (occupancy == PW'(DEPTH));
    reject     = discarding || full;
    we         = rx_valid && !reject;
    waddr      = wr_ptr[AW-1:0];
    wdata      = {rx_last, (rx_last ? beat_keep : {KEEP_W{1'b1}}), beat_data};
    tail_bytes = LEN_W'(count_ones(256'(beat_keep)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
      discarding <= 1'b0;
      beat_cnt   <= '0;
      len_valid  <= 1'b0;
      len_bytes  <= '0;
      drop_pulse <= 1'b0;
    end else begin
      len_valid  <= 1'b0;
      drop_pulse <= 1'b0;
      if (rx_valid) begin
        if (reject) begin
          wr_ptr   <= commit_ptr;
          beat_cnt <= '0;
          if (rx_last) begin
            discarding <= 1'b0;
            drop_pulse <= 1'b1;
          end else begin
            discarding <= 1'b1;
          end
        end else begin
          wr_ptr <= wr_ptr + PW'(1);
          if (rx_last) begin
            commit_ptr <= wr_ptr + PW'(1);
            len_valid  <= 1'b1;
            len_bytes  <= (beat_cnt << BSH) + tail_bytes;
            beat_cnt   <= '0;
          end else begin
            beat_cnt <= beat_cnt + LEN_W'(1);
          end
        end
      end
    end
  end

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= PW'(DEPTH));

  p_len_range_r6: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> (len_bytes != '0) && (len_bytes <= LEN_W'(DEPTH * KEEP_W)));

  p_drop_rewind_r7: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> (wr_ptr == commit_ptr) && !discarding);
endmodule

// File: rtl/frb_reader.sv
module frb_reader #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  localparam int KEEP_W = DATA_W / 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int WORD_W = DATA_W + KEEP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     commit_ptr,
  input  logic [WORD_W-1:0] rdata,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rd_ptr,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tlast
);
  logic [PW-1:0] rd_next;

  always_comb begin
    rd_next = rd_ptr + PW'(m_tvalid && m_tready);
    raddr   = rd_next[AW-1:0];
    {m_tlast, m_tkeep, m_tdata} = rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= '0;
      m_tvalid <= 1'b0;
    end else begin
      rd_ptr   <= rd_next;
      m_tvalid <= (commit_ptr != rd_next);
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

  p_only_committed_r5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> ((commit_ptr - rd_ptr) != '0) && ((commit_ptr - rd_ptr) <= PW'(DEPTH)));
endmodule

// File: rtl/frame_rx_buffer.sv
module frame_rx_buffer #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 16,
  localparam int KEEP_W = DATA_W / 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int WORD_W = DATA_W + KEEP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [0:DATA_W-1] rx_data,
  input  logic [0:KEEP_W-1] rx_keep,
  input  logic              rx_last,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              len_valid,
  output logic [LEN_W-1:0]  len_bytes,
  output logic              drop_pulse
);
  logic [DATA_W-1:0] beat_data;
  logic [KEEP_W-1:0] beat_keep;
  logic [PW-1:0]     commit_ptr;
  logic [PW-1:0]     rd_ptr;
  logic              we;
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     raddr;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] rdata;

  frb_order #(.DATA_W(DATA_W)) u_order (
    .asc_data (rx_data),
    .asc_keep (rx_keep),
    .desc_data(beat_data),
    .desc_keep(beat_keep)
  );

  frb_writer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_writer (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_last   (rx_last),
    .beat_data (beat_data),
    .beat_keep (beat_keep),
    .rd_ptr    (rd_ptr),
    .commit_ptr(commit_ptr),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .len_valid (len_valid),
    .len_bytes (len_bytes),
    .drop_pulse(drop_pulse)
  );

  frb_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(raddr),
    .rdata(rdata)
  );

  frb_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_reader (
    .clk       (clk),
    .rst       (rst),
    .commit_ptr(commit_ptr),
    .rdata     (rdata),
    .raddr     (raddr),
    .rd_ptr    (rd_ptr),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tdata   (m_tdata),
    .m_tkeep   (m_tkeep),
    .m_tlast   (m_tlast)
  );
endmodule

// File: tb/sim_frame_rx_buffer.sv
`timescale 1ns/1ps
module sim_frame_rx_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [0:63] rx_data = '0;
  logic [0:7]  rx_keep = '0;
  logic        rx_last = 1'b0;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic        m_tlast;
  logic        len_valid;
  logic [15:0] len_bytes;
  logic        drop_pulse;

  always #5 clk = ~clk;

  frame_rx_buffer u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_keep(rx_keep), .rx_last(rx_last), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .len_valid(len_valid), .len_bytes(len_bytes),
    .drop_pulse(drop_pulse)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [63:0] exp_d [0:2047];
  logic [7:0]  exp_k [0:2047];
  logic        exp_l [0:2047];
  int          exp_n = 0;
  int          rcv_n = 0;
  int          exp_len [0:255];
  int          len_exp_n = 0;
  int          len_seen = 0;
  int          drop_seen = 0;
  int          sink_mode = 1; // 0 random, 1 always ready, 2 stalled

  logic        hold_prev = 1'b0;
  logic [63:0] hold_d;
  logic [7:0]  hold_k;
  logic        hold_l;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // output monitor and sink
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_prev) begin
        chk(m_tvalid && m_tdata == hold_d && m_tkeep == hold_k && m_tlast == hold_l,
            "R8 held beat changed", {m_tlast, m_tkeep, m_tdata[54:0]}, {hold_l, hold_k, hold_d[54:0]});
      end
      case (sink_mode)
        0: m_tready = ($urandom % 3) != 0;
        1: m_tready = 1'b1;
        default: m_tready = 1'b0;
      endcase
      if (m_tvalid && m_tready) begin
        if (rcv_n >= exp_n) begin
          chk(1'b0, "R7 unexpected output beat", m_tdata, 64'd0);
        end else begin
          chk(m_tdata == exp_d[rcv_n], "R2 data order", m_tdata, exp_d[rcv_n]);
          chk(m_tkeep == exp_k[rcv_n], "R3 keep", {56'd0, m_tkeep}, {56'd0, exp_k[rcv_n]});
          chk(m_tlast == exp_l[rcv_n], "R4 last", {63'd0, m_tlast}, {63'd0, exp_l[rcv_n]});
        end
        rcv_n++;
      end
      hold_prev = m_tvalid && !m_tready;
      hold_d = m_tdata; hold_k = m_tkeep; hold_l = m_tlast;
      if (len_valid) begin
        chk(len_seen < len_exp_n && int'(len_bytes) == exp_len[len_seen], "R6 frame length",
            {48'd0, len_bytes}, 64'(exp_len[len_seen]));
        len_seen++;
      end
      if (drop_pulse) drop_seen++;
    end
  end

  task automatic send_frame(input int nb, input int kb, input bit keepit, input bit gaps);
    logic [63:0] e;
    for (int b = 0; b < nb; b++) begin
      if (gaps) begin
        int idle = $urandom % 3;
        for (int g = 0; g < idle; g++) begin
          @(negedge clk);
          rx_valid = 1'b0;
          rx_data = {$urandom, $urandom};
          rx_last = $urandom % 2;
          rx_keep = $urandom;
        end
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data = {$urandom, $urandom};
      rx_last = (b == nb - 1);
      if (rx_last) begin
        for (int i = 0; i < 8; i++) rx_keep[i] = (i < kb);
      end else begin
        rx_keep = $urandom;
      end
      if (keepit) begin
        for (int j = 0; j < 64; j++) e[63-j] = rx_data[j];
        exp_d[exp_n] = e;
        if (rx_last) begin
          for (int i = 0; i < 8; i++) exp_k[exp_n][7-i] = rx_keep[i];
        end else begin
          exp_k[exp_n] = 8'hFF;
        end
        exp_l[exp_n] = rx_last;
        exp_n++;
      end
    end
    if (keepit) begin
      exp_len[len_exp_n] = 8 * (nb - 1) + kb;
      len_exp_n++;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last = 1'b0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((rcv_n != exp_n || m_tvalid) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(rcv_n == exp_n && !m_tvalid, req, 64'(rcv_n), 64'(exp_n));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!m_tvalid && !len_valid && !drop_pulse, "R9 outputs in reset",
        {61'd0, m_tvalid, len_valid, drop_pulse}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!m_tvalid && !len_valid && !drop_pulse, "R9 outputs after reset",
        {61'd0, m_tvalid, len_valid, drop_pulse}, 64'd0);
  endtask

  task automatic t_visibility();
    logic [63:0] e;
    sink_mode = 1;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      chk(!m_tvalid, "R5 early visibility", 64'(m_tvalid), 64'd0);
      rx_valid = 1'b1;
      rx_data = {$urandom, $urandom};
      rx_last = (b == 3);
      rx_keep = (b == 3) ? 8'b1110_0000 : 8'b0101_0011;
      for (int j = 0; j < 64; j++) e[63-j] = rx_data[j];
      exp_d[exp_n] = e;
      exp_k[exp_n] = (b == 3) ? 8'b1110_0000 : 8'hFF;
      exp_l[exp_n] = (b == 3);
      exp_n++;
    end
    exp_len[len_exp_n] = 27;
    len_exp_n++;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last = 1'b0;
    chk(!m_tvalid, "R5 not visible on commit cycle", 64'(m_tvalid), 64'd0);
    chk(len_valid && len_bytes == 16'd27, "R6 length strobe timing", {47'd0, len_valid, len_bytes}, {47'd0, 1'b1, 16'd27});
    @(negedge clk);
    chk(m_tvalid, "R5 visible after commit", 64'(m_tvalid), 64'd1);
    chk(!len_valid, "R6 single-cycle strobe", 64'(len_valid), 64'd0);
    drain("R1 visibility frame delivered");
  endtask

  task automatic t_random_frames();
    int l0 = len_seen;
    int d0 = drop_seen;
    sink_mode = 0;
    for (int f = 0; f < 12; f++) begin
      send_frame(1 + ($urandom % 20), 1 + ($urandom % 8), 1'b1, f[0]);
    end
    drain("R1 random frames delivered");
    chk(len_seen - l0 == 12, "R6 one strobe per frame", 64'(len_seen - l0), 64'd12);
    chk(drop_seen == d0, "R7 no drop when space", 64'(drop_seen - d0), 64'd0);
  endtask

  task automatic t_single_beat();
    sink_mode = 1;
    send_frame(1, 8, 1'b1, 1'b0);
    send_frame(1, 1, 1'b1, 1'b0);
    send_frame(2, 5, 1'b1, 1'b0);
    drain("R1 short frames delivered");
  endtask

  task automatic t_overflow();
    int d0 = drop_seen;
    int l0 = len_seen;
    sink_mode = 2;
    send_frame(40, 3, 1'b1, 1'b0);
    send_frame(30, 8, 1'b0, 1'b0);
    @(negedge clk);
    chk(drop_seen - d0 == 1, "R7 drop strobe", 64'(drop_seen - d0), 64'd1);
    send_frame(24, 6, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(drop_seen - d0 == 1, "R7 later frame kept", 64'(drop_seen - d0), 64'd1);
    chk(len_seen - l0 == 2, "R7 no length for dropped", 64'(len_seen - l0), 64'd2);
    sink_mode = 0;
    drain("R7 surviving frames delivered");
    sink_mode = 2;
    send_frame(64, 2, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk(drop_seen - d0 == 1, "R10 full-depth frame kept", 64'(drop_seen - d0), 64'd1);
    send_frame(1, 4, 1'b0, 1'b0);
    @(negedge clk);
    chk(drop_seen - d0 == 2, "R7 drop on full buffer", 64'(drop_seen - d0), 64'd2);
    sink_mode = 0;
    drain("R10 full-depth frame delivered");
    chk(len_seen - l0 == 3, "R6 length count", 64'(len_seen - l0), 64'd3);
  endtask

  initial begin
    t_reset();
    t_visibility();
    t_random_frames();
    t_single_beat();
    t_overflow();
    t_random_frames();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule